// File: doc/BRIEF.md
# Pulse-Swallow Programmable Integer Divider

This block divides a fast input clock by an integer ratio chosen at run time. A dual-band modulus prescaler produces one tick every N+1 or N input clocks. N is 32 in the low band and 47 in the high band. Two down-counters run on those ticks. The program counter sets how many prescaler periods make up one output period. The swallow counter sets how many of those periods use the larger modulus. While the swallow counter has work left, the mode flag is low and the prescaler divides by N+1. Once the swallow counter reaches zero, the flag goes high and the prescaler divides by N for the rest of the output period.

When the program counter reaches zero, the block reloads both counters and the band from the programmed inputs, clears the mode flag and emits a one-clock output pulse. The output period is therefore N·P + S input clocks, provided S ≤ P. The block is meant for the feedback path of an integer-N frequency synthesizer. The band select sets the prescaler modulus and also supplies one bit of the P load value.

Top module: `pulse_swallow_div`

## Requirements
- R1: With band 0 (sel_i=0), the spacing between pulse_o rises is 32·P + S input clocks, where P = 64 + p_prog_i.
- R2: With band 1 (sel_i=1), the spacing between pulse_o rises is 47·P + S input clocks, where P = 96 + p_prog_i.
- R3: The P load value is built as bit 6 = 1, bit 5 = sel_i, bits 4:0 = p_prog_i, so P is never zero.
- R4: In band 0, bit 5 of s_prog_i is ignored (S = s_prog_i[4:0]). In band 1, S = s_prog_i.
- R5: mod_o is low from a reload with S > 0 for exactly S·(N+1) input clocks, then high until the next reload. With S = 0 it is high for the whole period.
- R6: The swallow count does not change while mod_o is high, except at a reload.
- R7: pulse_o is high for exactly one clock, in the clock after each reload.
- R8: sel_i, p_prog_i and s_prog_i are sampled only at a reload. Changes between reloads do not affect the period in progress.
- R9: During reset, pulse_o = 0 and mod_o = 1. The first pulse comes 32 clocks after reset is released.
- R10: The prescaler modulus and mod_o change only on a prescaler tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Band select: 0 gives modulus 32/33, 1 gives 47/48 |
| p_prog_i | input | 5 | Low five bits of the program count |
| s_prog_i | input | 6 | Swallow count |
| pulse_o | output | 1 | One-clock pulse per output period |
| mod_o | output | 1 | Mode flag: 0 selects the larger prescaler modulus |

## Verification
The ratio formula, and the property that ties each reload to the swallow count, both rely on S ≤ P. The inputs are only sampled at reload, so the design need not hold them stable at any other time. The stimulus keeps S at 48 or less and P at 64 or more, so this condition always holds. It also changes the programming inputs only at the falling edge, either straight after a pulse or in the middle of a period. Mid-period changes test that they are ignored until the next reload.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned STG_W    = 4;  // 2**STG_W prescaler stages of 2/3
  localparam int unsigned P_W      = 7;
  localparam int unsigned S_W      = 6;
  localparam int unsigned P_PROG_W = P_W - 2;
  typedef enum logic {BAND_LO = 1'b0, BAND_HI = 1'b1} band_e;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned STG_W = psd_pkg::STG_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic band_i,
  input  logic mod_i,
  output logic tick_o
);
  logic [STG_W-1:0] stg_q;
  logic [1:0]       cell_q;
  logic             last_stg, div3, cell_end;

  assign last_stg = &stg_q;
  // low band: one divide-by-3 when mod low; high band: one divide-by-2 when mod high
  assign div3     = band_i ? ~(last_stg & mod_i) : (last_stg & ~mod_i);
  assign cell_end = div3 ? (cell_q == 2'd2) : (cell_q == 2'd1);
  assign tick_o   = cell_end & last_stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      cell_q <= '0;
    end else if (cell_end) begin
      cell_q <= '0;
      stg_q  <= stg_q + 1'b1;
    end else begin
      cell_q <= cell_q + 1'b1;
    end
  end
endmodule

// File: rtl/psd_prog_ctr.sv
module psd_prog_ctr #(
  parameter int unsigned P_W = psd_pkg::P_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [P_W-1:0] load_i,
  output logic           reload_o,
  output logic [P_W-1:0] cnt_o
);
  logic [P_W-1:0] cnt_q;

  assign reload_o = tick_i && (cnt_q == P_W'(1));
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= P_W'(1);
    else if (reload_o) cnt_q <= load_i;
    else if (tick_i)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int unsigned S_W = psd_pkg::S_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           reload_i,
  input  logic [S_W-1:0] load_i,
  output logic [S_W-1:0] cnt_o,
  output logic           mod_o
);
  logic [S_W-1:0] cnt_q;
  logic           mod_q;

  assign cnt_o = cnt_q;
  assign mod_o = mod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mod_q <= 1'b1;
    end else if (reload_i) begin
      cnt_q <= load_i;
      mod_q <= (load_i == '0);
    end else if (tick_i && !mod_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == S_W'(1)) mod_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int unsigned STG_W = psd_pkg::STG_W,
  parameter int unsigned P_W   = psd_pkg::P_W,
  parameter int unsigned S_W   = psd_pkg::S_W,
  localparam int unsigned PP_W = P_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  logic [PP_W-1:0] p_prog_i,
  input  logic [S_W-1:0]  s_prog_i,
  output logic            pulse_o,
  output logic            mod_o
);
  logic           sel_q, pulse_q, pre_tick, reload, mod_q;
  logic [P_W-1:0] p_load, p_cnt;
  logic [S_W-1:0] s_load, s_cnt;

  // top P bit fixed high, next bit follows band select
  assign p_load = {1'b1, sel_i, p_prog_i};

  // top S bit only usable in the high band
  generate
    if (S_W > 1) begin : g_s_mask
      assign s_load = {sel_i & s_prog_i[S_W-1], s_prog_i[S_W-2:0]};
    end else begin : g_s_plain
      assign s_load = s_prog_i;
    end
  endgenerate

  psd_prescaler #(.STG_W(STG_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .band_i(sel_q), .mod_i(mod_q), .tick_o(pre_tick)
  );

  psd_prog_ctr #(.P_W(P_W)) u_pctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(pre_tick), .load_i(p_load),
    .reload_o(reload), .cnt_o(p_cnt)
  );

  psd_swallow_ctr #(.S_W(S_W)) u_sctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(pre_tick), .reload_i(reload),
    .load_i(s_load), .cnt_o(s_cnt), .mod_o(mod_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= psd_pkg::BAND_LO;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= reload;
      if (reload) sel_q <= sel_i;
    end
  end

  assign pulse_o = pulse_q;
  assign mod_o   = mod_q;
endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int unsigned P_W = psd_pkg::P_W,
  parameter int unsigned S_W = psd_pkg::S_W
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tick,
  input logic           reload,
  input logic           mod,
  input logic           sel_q,
  input logic           pulse,
  input logic [P_W-1:0] p_cnt,
  input logic [S_W-1:0] s_cnt
);
  p_p_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni) p_cnt != '0);
  p_s_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod && !reload) |=> $stable(s_cnt));
  p_pulse_on_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload |=> pulse);
  p_pulse_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !pulse);
  p_mod_after_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |-> (mod == (s_cnt == '0)));
  p_sel_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload |=> $stable(sel_q));
  p_mod_on_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(mod));
endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(.P_W(P_W), .S_W(S_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(pre_tick), .reload(reload), .mod(mod_q),
  .sel_q(sel_q), .pulse(pulse_o), .p_cnt(p_cnt), .s_cnt(s_cnt)
);

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic [4:0] pprog = '0;
  logic [5:0] sprog = '0;
  logic       pulse, mod;
  int         cyc = 0;
  int         n_chk = 0;
  int         n_bad = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pulse_swallow_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .p_prog_i(pprog), .s_prog_i(sprog),
    .pulse_o(pulse), .mod_o(mod)
  );

  // {sel, p_prog, s_prog, expected clocks per output period}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 5'd11, 6'd0,  16'd2400},  // R1 P=75
    {1'b0, 5'd14, 6'd20, 16'd2516},  // R1 P=78
    {1'b0, 5'd11, 6'd31, 16'd2431},  // R1 S max
    {1'b0, 5'd11, 6'd37, 16'd2405},  // R4 bit5 dropped -> S=5
    {1'b1, 5'd9,  6'd0,  16'd4935},  // R2 P=105
    {1'b1, 5'd10, 6'd45, 16'd5027},  // R2
    {1'b1, 5'd26, 6'd48, 16'd5782},  // R2 P=122 S=48
    {1'b1, 5'd14, 6'd20, 16'd5190}   // R2 R3
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int at);
    do @(negedge clk); while (!pulse);
    at = cyc;
  endtask

  task automatic apply(input logic s, input logic [4:0] p, input logic [5:0] q);
    sel = s; pprog = p; sprog = q;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=%0d exp=0", cyc);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int t0, t1, t2, t3, tm;
    repeat (3) @(negedge clk);
    chk(pulse == 1'b0, "R9 reset pulse", pulse, 0);
    chk(mod == 1'b1, "R9 reset mod", mod, 1);
    apply(1'b0, 5'd11, 6'd0);
    rst_n = 1'b1;
    t0 = cyc;
    wait_pulse(t1);
    chk(t1 - t0 == 32, "R9 first pulse", t1 - t0, 32);
    @(negedge clk);
    chk(pulse == 1'b0, "R7 width", pulse, 0);

    // vector walk: apply, next reload loads it, measure the following period
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][27], VEC[i][26:22], VEC[i][21:16]);
      wait_pulse(t1);
      wait_pulse(t2);
      chk(t2 - t1 == int'(VEC[i][15:0]), $sformatf("R1/R2/R3/R4/R6 vec%0d", i),
          t2 - t1, int'(VEC[i][15:0]));
    end

    // R8: changes between reloads are not used until the next reload
    apply(1'b0, 5'd11, 6'd0);
    wait_pulse(t1);
    wait_pulse(t1);
    apply(1'b1, 5'd9, 6'd0);
    repeat (1000) @(negedge clk);
    apply(1'b0, 5'd14, 6'd3);
    wait_pulse(t2);
    chk(t2 - t1 == 2400, "R8 period in progress", t2 - t1, 2400);
    wait_pulse(t3);
    chk(t3 - t2 == 2499, "R8 latest value used", t3 - t2, 2499);

    // R5: mod timing with S=20 in high band
    apply(1'b1, 5'd14, 6'd20);
    wait_pulse(t1);
    chk(mod == 1'b0, "R5 mod low after reload", mod, 0);
    do @(negedge clk); while (!mod);
    tm = cyc;
    chk(tm - t1 == 960, "R5 mod rise R10", tm - t1, 960);

    // R5: S=0 keeps mod high
    apply(1'b0, 5'd11, 6'd0);
    wait_pulse(t1);
    chk(mod == 1'b1, "R5 S=0 mod high", mod, 1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule